// File: doc/BRIEF.md
# Registered Sum-of-Products Output Macrocell Array

This block models the output side of a small sum-of-products programmable logic device. A set of dedicated inputs and one feedback signal per macrocell form the literal bus. Each signal contributes a true literal and a complement literal. Every macrocell has eight programmable AND terms. Configuration masks pick which literals each term uses. The eight terms are ORed, and a polarity bit can invert the result. The result is then either captured in the macrocell's register or sent straight to the pin.

A ninth term in each macrocell drives the enable of a tri-state pin model. In local-clock mode, that same term clocks the register instead. Two product terms are common to every macrocell: one clears all registers asynchronously and the other sets them all on the next clock edge. Each macrocell also chooses what it feeds back into the array: its register value or the value seen on its pin.

All configuration is presented as static input vectors. The block has a single clock domain. In local-clock mode the register loads on a global clock edge at which the local term is seen to have risen since the previous edge.

Top module: `pal_mcell_array`

## Requirements
- R1: While `rst_n` is low, every macrocell register is cleared. After release, a register whose sum is false stays at 0.
- R2: Literal bus layout: signal k has its true literal at bit 2k and its complement at bit 2k+1. Signals 0..N_IN-1 are `in_di`, and signal N_IN+m is the feedback of macrocell m. A term whose mask is all zero evaluates true. A term that connects both literals of one signal evaluates false. The sum is the OR of the cell's eight terms. Term t of cell m occupies `cfg_sum[(m*8+t)*LW +: LW]`, with LW = 2*(N_IN+N_MC).
- R3: When `cfg_inv[m]`=1, the sum is inverted before it reaches the register and the combinational path.
- R4: When `cfg_reg[m]`=0, `pin_do[m]` follows the inputs within the same cycle. When `cfg_reg[m]`=1, `pin_do[m]` shows the register, which takes the new value at the next clock edge.
- R5: When `cfg_fbpin[m]`=0, the feedback literal is the register value. When it is 1, the feedback literal is `pin_di[m]`.
- R6: While the common reset term (`cfg_ar`) is true, every registered output reads 0 at once, without a clock edge. Registers stay cleared across clock edges, even when the preset term is also true.
- R7: When the common preset term (`cfg_sp`) is true and the reset term is false, every register becomes 1 at the next clock edge, and not before it.
- R8: When `cfg_lclk[m]`=0, `pin_oe[m]` equals the cell's enable term (`cfg_oe`). When `cfg_lclk[m]`=1, `pin_oe[m]` is held at 1.
- R9: When `cfg_lclk[m]`=1, the register loads only at a clock edge where the enable term is true and was false at the previous edge. At all other edges it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_di | input | N_IN | Dedicated logic inputs |
| pin_di | input | N_MC | Value observed on each pin |
| cfg_sum | input | N_MC*8*LW | AND-plane masks of the sum terms |
| cfg_oe | input | N_MC*LW | Mask of each cell's enable / local-clock term |
| cfg_ar | input | LW | Mask of the common asynchronous reset term |
| cfg_sp | input | LW | Mask of the common synchronous preset term |
| cfg_inv | input | N_MC | Polarity invert per cell |
| cfg_reg | input | N_MC | 1 = registered output, 0 = combinational |
| cfg_fbpin | input | N_MC | 1 = pin feedback, 0 = register feedback |
| cfg_lclk | input | N_MC | 1 = local-term clock, 0 = global clock |
| pin_do | output | N_MC | Output value driven toward each pin |
| pin_oe | output | N_MC | Tri-state enable per pin |

## Verification
The bench uses the default parameters: four dedicated inputs and four macrocells, giving a 16-bit literal bus. This is enough to give each scenario its own cell while the other cells stay quiet. It also lets a common reset or preset term be seen acting on all four registers at once. Feedback literals sit above the input literals, so the toggle test and the pin-feedback test both use the upper half of the literal bus.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int TERMS_PER_CELL = 8;

    typedef enum logic {CLK_GLOBAL = 1'b0, CLK_LOCAL = 1'b1} clk_src_e;
    typedef enum logic {FB_REG = 1'b0, FB_PIN = 1'b1} fb_src_e;
    typedef enum logic {OUT_COMB = 1'b0, OUT_REG = 1'b1} out_src_e;
endpackage

// File: rtl/pal_pterm.sv
module pal_pterm #(
    parameter int LW = 16
) (
    input  logic [LW-1:0] lits,
    input  logic [LW-1:0] mask,
    output logic          hit
);
    // Unconnected literals read as 1, so an empty mask yields a true term.
    always_comb hit = &(lits | ~mask);
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
#(
    parameter int LW  = 16,
    parameter int NPT = TERMS_PER_CELL
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LW-1:0]   lits,
    input  logic [NPT*LW-1:0] sum_mask,
    input  logic [LW-1:0]   oe_mask,
    input  logic            inv,
    input  out_src_e        out_sel,
    input  fb_src_e         fb_sel,
    input  clk_src_e        clk_sel,
    input  logic            pin_di,
    input  logic            ar_hit,
    input  logic            sp_hit,
    output logic            out_val,
    output logic            oe,
    output logic            fb_lit,
    output logic            q_raw,
    output logic            ld_en
);
    logic [NPT-1:0] term_hit;
    logic           oe_hit;
    logic           d_val;
    logic           lclk_prev;
    logic           q_q;

    for (genvar t = 0; t < NPT; t++) begin : g_term
        pal_pterm #(.LW(LW)) u_term (
            .lits (lits),
            .mask (sum_mask[t*LW +: LW]),
            .hit  (term_hit[t])
        );
    end

    pal_pterm #(.LW(LW)) u_oe_term (
        .lits (lits),
        .mask (oe_mask),
        .hit  (oe_hit)
    );

    always_comb d_val = (|term_hit) ^ inv;

    // Rising-edge detection of the local clock term, sampled on the global clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lclk_prev <= 1'b0;
        else        lclk_prev <= oe_hit;
    end

    always_comb begin
        unique case (clk_sel)
            CLK_LOCAL:  ld_en = oe_hit & ~lclk_prev;
            CLK_GLOBAL: ld_en = 1'b1;
            default:    ld_en = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q_q <= 1'b0;
        else if (ar_hit) q_q <= 1'b0;
        else if (sp_hit) q_q <= 1'b1;
        else if (ld_en)  q_q <= d_val;
    end

    always_comb begin
        q_raw = q_q;
        unique case (out_sel)
            OUT_REG:  out_val = q_q & ~ar_hit;
            OUT_COMB: out_val = d_val;
            default:  out_val = d_val;
        endcase
        unique case (clk_sel)
            CLK_LOCAL:  oe = 1'b1;
            CLK_GLOBAL: oe = oe_hit;
            default:    oe = oe_hit;
        endcase
        unique case (fb_sel)
            FB_PIN:  fb_lit = pin_di;
            FB_REG:  fb_lit = q_q;
            default: fb_lit = q_q;
        endcase
    end
endmodule

// File: rtl/pal_mcell_array.sv
module pal_mcell_array
    import pal_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int N_MC = 4,
    localparam int NPT  = TERMS_PER_CELL,
    localparam int NSIG = N_IN + N_MC,
    localparam int LW   = 2 * NSIG
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        in_di,
    input  logic [N_MC-1:0]        pin_di,
    input  logic [N_MC*NPT*LW-1:0] cfg_sum,
    input  logic [N_MC*LW-1:0]     cfg_oe,
    input  logic [LW-1:0]          cfg_ar,
    input  logic [LW-1:0]          cfg_sp,
    input  logic [N_MC-1:0]        cfg_inv,
    input  logic [N_MC-1:0]        cfg_reg,
    input  logic [N_MC-1:0]        cfg_fbpin,
    input  logic [N_MC-1:0]        cfg_lclk,
    output logic [N_MC-1:0]        pin_do,
    output logic [N_MC-1:0]        pin_oe
);
    logic [NSIG-1:0] sig;
    logic [LW-1:0]   lits;
    logic [N_MC-1:0] fb;
    logic [N_MC-1:0] q_raw;
    logic [N_MC-1:0] ld_en;
    logic            ar_hit;
    logic            sp_hit;

    always_comb sig = {fb, in_di};

    for (genvar k = 0; k < NSIG; k++) begin : g_lit
        assign lits[2*k]   = sig[k];
        assign lits[2*k+1] = ~sig[k];
    end

    pal_pterm #(.LW(LW)) u_ar_term (.lits(lits), .mask(cfg_ar), .hit(ar_hit));
    pal_pterm #(.LW(LW)) u_sp_term (.lits(lits), .mask(cfg_sp), .hit(sp_hit));

    for (genvar m = 0; m < N_MC; m++) begin : g_cell
        pal_macrocell #(.LW(LW), .NPT(NPT)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .lits     (lits),
            .sum_mask (cfg_sum[m*NPT*LW +: NPT*LW]),
            .oe_mask  (cfg_oe[m*LW +: LW]),
            .inv      (cfg_inv[m]),
            .out_sel  (out_src_e'(cfg_reg[m])),
            .fb_sel   (fb_src_e'(cfg_fbpin[m])),
            .clk_sel  (clk_src_e'(cfg_lclk[m])),
            .pin_di   (pin_di[m]),
            .ar_hit   (ar_hit),
            .sp_hit   (sp_hit),
            .out_val  (pin_do[m]),
            .oe       (pin_oe[m]),
            .fb_lit   (fb[m]),
            .q_raw    (q_raw[m]),
            .ld_en    (ld_en[m])
        );
    end
endmodule

// File: rtl/pal_mcell_array_chk.sv
module pal_mcell_array_chk #(
    parameter int N_MC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ar_hit,
    input logic            sp_hit,
    input logic [N_MC-1:0] q_raw,
    input logic [N_MC-1:0] ld_en,
    input logic [N_MC-1:0] cfg_reg,
    input logic [N_MC-1:0] cfg_lclk,
    input logic [N_MC-1:0] pin_do,
    input logic [N_MC-1:0] pin_oe
);
    assert_reset_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ar_hit |=> (q_raw == '0));

    assert_preset_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_hit && !ar_hit) |=> (q_raw == '1));

    assert_reg_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ar_hit |-> (((pin_do ^ q_raw) & cfg_reg) == '0));

    assert_lclk_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe | ~cfg_lclk) == '1));

    for (genvar i = 0; i < N_MC; i++) begin : g_hold
        assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (!ar_hit && !sp_hit && !ld_en[i]) |=> $stable(q_raw[i]));
    end
endmodule

bind pal_mcell_array pal_mcell_array_chk #(.N_MC(N_MC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ar_hit   (ar_hit),
    .sp_hit   (sp_hit),
    .q_raw    (q_raw),
    .ld_en    (ld_en),
    .cfg_reg  (cfg_reg),
    .cfg_lclk (cfg_lclk),
    .pin_do   (pin_do),
    .pin_oe   (pin_oe)
);

// File: tb/pal_mcell_array_tb.sv
module pal_mcell_array_tb;
    localparam int N_IN = 4;
    localparam int N_MC = 4;
    localparam int NPT  = 8;
    localparam int LW   = 2 * (N_IN + N_MC);
    localparam logic [LW-1:0] NEVER = 16'h0003; // in0 & ~in0

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_IN-1:0] in_di = '0;
    logic [N_MC-1:0] pin_di = '0;
    logic [LW-1:0] sumt [N_MC][NPT];
    logic [LW-1:0] oet [N_MC];
    logic [N_MC*NPT*LW-1:0] cfg_sum;
    logic [N_MC*LW-1:0] cfg_oe;
    logic [LW-1:0] cfg_ar, cfg_sp;
    logic [N_MC-1:0] cfg_inv, cfg_reg, cfg_fbpin, cfg_lclk;
    logic [N_MC-1:0] pin_do, pin_oe;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    always_comb begin
        for (int m = 0; m < N_MC; m++) begin
            cfg_oe[m*LW +: LW] = oet[m];
            for (int t = 0; t < NPT; t++) cfg_sum[(m*NPT+t)*LW +: LW] = sumt[m][t];
        end
    end

    pal_mcell_array #(.N_IN(N_IN), .N_MC(N_MC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_di(in_di), .pin_di(pin_di),
        .cfg_sum(cfg_sum), .cfg_oe(cfg_oe), .cfg_ar(cfg_ar), .cfg_sp(cfg_sp),
        .cfg_inv(cfg_inv), .cfg_reg(cfg_reg), .cfg_fbpin(cfg_fbpin),
        .cfg_lclk(cfg_lclk), .pin_do(pin_do), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic cfg_clear();
        for (int m = 0; m < N_MC; m++) begin
            oet[m] = NEVER;
            for (int t = 0; t < NPT; t++) sumt[m][t] = NEVER;
        end
        cfg_ar = NEVER; cfg_sp = NEVER;
        cfg_inv = '0; cfg_reg = '0; cfg_fbpin = '0; cfg_lclk = '0;
        in_di = '0; pin_di = '0;
        tick(); tick();
    endtask

    task automatic t_reset();
        @(negedge clk);
        cfg_clear();
        rst_n = 1'b0;
        cfg_reg = '1;
        settle();
        check("R1 reset outputs", pin_do, 4'h0);
        check("R1 reset enables", pin_oe, 4'h0);
        tick(); rst_n = 1'b1;
        tick(); tick();
        check("R1 after release", pin_do, 4'h0);
    endtask

    task automatic t_terms();
        cfg_clear();
        sumt[0][0] = '0; settle();
        check("R2 empty term true", pin_do[0], 1);
        sumt[0][0] = NEVER; settle();
        check("R2 contradictory term false", pin_do[0], 0);
        sumt[0][3] = 16'h0009; // in0 & ~in1
        in_di = 4'b0001; settle();
        check("R2 term in0&~in1 true", pin_do[0], 1);
        in_di = 4'b0011; settle();
        check("R2 term in0&~in1 false", pin_do[0], 0);
    endtask

    task automatic t_polarity();
        cfg_clear();
        sumt[0][5] = 16'h0001; cfg_inv[0] = 1'b1;
        in_di = 4'b0001; settle();
        check("R3 inverted true sum", pin_do[0], 0);
        in_di = 4'b0000; settle();
        check("R3 inverted false sum", pin_do[0], 1);
    endtask

    task automatic t_outsel();
        cfg_clear();
        cfg_reg[1] = 1'b1; sumt[1][0] = 16'h0010; // in2
        in_di = 4'b0100; settle();
        check("R4 registered before edge", pin_do[1], 0);
        tick();
        check("R4 registered after edge", pin_do[1], 1);
        cfg_reg[1] = 1'b0; in_di = 4'b0000; settle();
        check("R4 combinational same cycle", pin_do[1], 0);
    endtask

    task automatic t_feedback();
        cfg_clear();
        cfg_reg[2] = 1'b1; sumt[2][0] = 16'h2000; // ~fb2
        tick();
        check("R5 register feedback toggle 1", pin_do[2], 1);
        tick();
        check("R5 register feedback toggle 0", pin_do[2], 0);
        cfg_fbpin[2] = 1'b1; sumt[2][0] = 16'h1000; // pin2 true
        pin_di[2] = 1'b1; tick();
        check("R5 pin feedback high", pin_do[2], 1);
        pin_di[2] = 1'b0; tick();
        check("R5 pin feedback low", pin_do[2], 0);
    endtask

    task automatic t_areset();
        cfg_clear();
        cfg_reg = '1; sumt[3][0] = '0;
        tick();
        check("R6 setup register high", pin_do[3], 1);
        cfg_ar = 16'h0040; cfg_sp = '0; // reset = in3, preset always
        in_di = 4'b1000; settle();
        check("R6 reset acts without edge", pin_do[3], 0);
        tick();
        check("R6 reset beats preset", pin_do, 4'h0);
        in_di = 4'b0000; settle();
        check("R6 cleared after release", pin_do[3], 0);
        tick();
        check("R6 preset after reset release", pin_do, 4'hF);
    endtask

    task automatic t_preset();
        cfg_clear();
        cfg_reg = '1; cfg_sp = 16'h0040; // preset = in3
        tick();
        check("R7 all low first", pin_do, 4'h0);
        in_di = 4'b1000; settle();
        check("R7 no change before edge", pin_do, 4'h0);
        tick();
        check("R7 all set at edge", pin_do, 4'hF);
        in_di = 4'b0000; tick();
        check("R7 released reloads sums", pin_do, 4'h0);
    endtask

    task automatic t_enable();
        cfg_clear();
        oet[0] = 16'h0004; // in1
        in_di = 4'b0010; settle();
        check("R8 enable term true", pin_oe[0], 1);
        in_di = 4'b0000; settle();
        check("R8 enable term false", pin_oe[0], 0);
        cfg_lclk[0] = 1'b1; settle();
        check("R8 local clock forces enable", pin_oe[0], 1);
    endtask

    task automatic t_localclk();
        cfg_clear();
        cfg_reg[0] = 1'b1; cfg_lclk[0] = 1'b1;
        oet[0] = 16'h0004; sumt[0][0] = 16'h0010; // clock in1, data in2
        in_di = 4'b0100; tick(); tick();
        check("R9 no load without rise", pin_do[0], 0);
        in_di = 4'b0110; tick();
        check("R9 load on term rise", pin_do[0], 1);
        in_di = 4'b0010; tick(); tick();
        check("R9 hold while term stays high", pin_do[0], 1);
        in_di = 4'b0000; tick();
        in_di = 4'b0010; tick();
        check("R9 second rise loads new data", pin_do[0], 0);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        t_reset();
        t_terms();
        t_polarity();
        t_outsel();
        t_feedback();
        t_areset();
        t_preset();
        t_enable();
        t_localclk();
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end
endmodule